// File: doc/BRIEF.md
# Four-Mode Fixed-Point Radix-2 Butterfly

This unit computes one radix-2 complex butterfly on two complex operands `A` and `B` and a complex twiddle `W`. It returns the two complex results `X` and `Y`. A two-bit mode chooses where the twiddle multiply sits. In time-decimated form, `B` is multiplied before the sum and difference. In frequency-decimated form, the difference is multiplied after it is formed. Either form can also rotate the twiddle product by a quarter turn (multiplication by −j). This rotation lets a twiddle table that holds only one quadrant serve the next quadrant as well. The forward and inverse transforms can then share a single table.

All values are 16-bit signed Q1.15. One real multiplier is shared over four cycles to form the complex product. The product is rounded and saturated back to Q1.15. Every sum or difference is halved, so the data cannot grow from one stage to the next. An operation starts on a single `start` cycle. It finishes with a one-cycle `done` pulse exactly 16 cycles later, in every mode. A controller issues one butterfly, waits for `done`, and then issues the next.

Top module: `fft_bfly_unit`

## Requirements
- R1: `mode[1]` selects the form: 0 multiplies before the add/subtract (time-decimated), 1 multiplies after it (frequency-decimated). `mode[0]` = 1 adds the quarter-turn rotation to the twiddle product.
- R2: In time-decimated modes, with P = B·W (rotated when `mode[0]`=1): X = (A+P)/2 and Y = (A−P)/2.
- R3: In frequency-decimated modes: X = (A+B)/2 and Y = D·W, with D = (A−B)/2 and the product rotated when `mode[0]`=1.
- R4: The rotation maps a product (re, im) to (im, −re). When re = −32768, the negated value saturates to 32767.
- R5: The real part re·wr − im·wi and the imaginary part re·wi + im·wr are each formed at full precision. Each is then rounded as floor((s + 16384) / 32768) and saturated to [−32768, 32767].
- R6: Each halved sum or difference is the full 17-bit result shifted right arithmetically by one bit (rounded toward minus infinity).
- R7: `done` goes high exactly 16 rising edges after the edge that accepts `start`. It stays high for one cycle only. `busy` is high from the accepting edge until the edge that raises `done`.
- R8: `start` is ignored while `busy` is high. `start` held high is accepted again on the first edge after `done` rises.
- R9: Mode and operands are captured on the accepting edge. Changing them while `busy` is high does not alter the result.
- R10: The outputs change only on the edge that raises `done`, and hold their value until the next `done`. After reset, all outputs, `busy` and `done` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation when idle |
| mode | input | 2 | Butterfly variant (see R1) |
| a_re | input | 16 | Operand A, real part, Q1.15 |
| a_im | input | 16 | Operand A, imaginary part |
| b_re | input | 16 | Operand B, real part |
| b_im | input | 16 | Operand B, imaginary part |
| w_re | input | 16 | Twiddle, real part |
| w_im | input | 16 | Twiddle, imaginary part |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| x_re | output | 16 | Result X, real part |
| x_im | output | 16 | Result X, imaginary part |
| y_re | output | 16 | Result Y, real part |
| y_im | output | 16 | Result Y, imaginary part |

## Verification
The assertions check the timing on every cycle:
- `done` lasts a single cycle and never coincides with `busy`.
- A busy period never runs past its 16-cycle window, so a stray `start` cannot restart or extend it.
- The result ports stay steady at all times except the `done` cycle.

The arithmetic is checked only by the bench scenarios. A behavioural model compares the results of all four modes against integer arithmetic, including saturating products, negation at the most negative value, and operands altered in mid-operation.

// File: rtl/fft_bfly_unit.sv
module fft_bfly_unit #(
  parameter int DW  = 16,
  parameter int LAT = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [1:0]           mode,
  input  logic signed [DW-1:0] a_re,
  input  logic signed [DW-1:0] a_im,
  input  logic signed [DW-1:0] b_re,
  input  logic signed [DW-1:0] b_im,
  input  logic signed [DW-1:0] w_re,
  input  logic signed [DW-1:0] w_im,
  output logic                 busy,
  output logic                 done,
  output logic signed [DW-1:0] x_re,
  output logic signed [DW-1:0] x_im,
  output logic signed [DW-1:0] y_re,
  output logic signed [DW-1:0] y_im
);
  localparam int PW = 2 * DW;
  localparam int AW = PW + 1;
  localparam int CW = $clog2(LAT);
  localparam logic signed [AW:0]   LIM_HI = (AW+1)'((1 << (DW-1)) - 1);
  localparam logic signed [AW:0]   LIM_LO = -LIM_HI - 1;
  localparam logic signed [DW-1:0] MAXV = {1'b0, {(DW-1){1'b1}}};
  localparam logic signed [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};

  function automatic logic signed [DW-1:0] rnd_sat(input logic signed [AW-1:0] v);
    logic signed [AW:0] t;
    t = {v[AW-1], v};
    t = t + (AW+1)'(1 << (DW-2));
    t = t >>> (DW-1);
    if (t > LIM_HI)      return MAXV;
    else if (t < LIM_LO) return MINV;
    else                 return t[DW-1:0];
  endfunction

  function automatic logic signed [DW-1:0] half(input logic signed [DW-1:0] p,
                                                input logic signed [DW-1:0] q,
                                                input logic sub);
    logic signed [DW:0] s;
    s = sub ? ({p[DW-1], p} - {q[DW-1], q}) : ({p[DW-1], p} + {q[DW-1], q});
    return s[DW:1];
  endfunction

  function automatic logic signed [DW-1:0] neg_sat(input logic signed [DW-1:0] v);
    return (v == MINV) ? MAXV : -v;
  endfunction

  logic [CW-1:0]        cnt;
  logic [1:0]           mode_q;
  logic signed [DW-1:0] ar, ai, br, bi, wr, wi, mr, mi, pr, pi;
  logic signed [AW-1:0] acc_re, acc_im;
  logic signed [DW-1:0] mul_a, mul_b;
  logic signed [PW-1:0] prod;
  logic signed [AW-1:0] prod_x;
  logic signed [DW-1:0] rr, ri;

  always_comb begin
    case (cnt)
      CW'(2):  begin mul_a = mi; mul_b = wi; end
      CW'(3):  begin mul_a = mr; mul_b = wi; end
      CW'(4):  begin mul_a = mi; mul_b = wr; end
      default: begin mul_a = mr; mul_b = wr; end
    endcase
  end

  assign prod   = mul_a * mul_b;
  assign prod_x = AW'(prod);
  assign rr     = rnd_sat(acc_re);
  assign ri     = rnd_sat(acc_im);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; cnt <= '0; mode_q <= '0;
      ar <= '0; ai <= '0; br <= '0; bi <= '0; wr <= '0; wi <= '0;
      mr <= '0; mi <= '0; pr <= '0; pi <= '0; acc_re <= '0; acc_im <= '0;
      x_re <= '0; x_im <= '0; y_re <= '0; y_im <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1; cnt <= '0; mode_q <= mode;
          ar <= a_re; ai <= a_im; br <= b_re; bi <= b_im; wr <= w_re; wi <= w_im;
        end
      end else begin
        cnt <= cnt + 1'b1;
        case (cnt)
          CW'(0): begin
            mr <= mode_q[1] ? half(ar, br, 1'b1) : br;
            mi <= mode_q[1] ? half(ai, bi, 1'b1) : bi;
          end
          CW'(1): acc_re <= prod_x;
          CW'(2): acc_re <= acc_re - prod_x;
          CW'(3): acc_im <= prod_x;
          CW'(4): acc_im <= acc_im + prod_x;
          CW'(5): begin
            pr <= mode_q[0] ? ri : rr;
            pi <= mode_q[0] ? neg_sat(rr) : ri;
          end
          default: ;
        endcase
        if (cnt == CW'(LAT-1)) begin
          busy <= 1'b0;
          done <= 1'b1;
          if (mode_q[1]) begin
            x_re <= half(ar, br, 1'b0); x_im <= half(ai, bi, 1'b0);
            y_re <= pr;                 y_im <= pi;
          end else begin
            x_re <= half(ar, pr, 1'b0); x_im <= half(ai, pi, 1'b0);
            y_re <= half(ar, pr, 1'b1); y_im <= half(ai, pi, 1'b1);
          end
        end
      end
    end
  end
endmodule

// File: rtl/fft_bfly_unit_chk.sv
module fft_bfly_unit_chk #(
  parameter int DW  = 16,
  parameter int LAT = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic [DW-1:0] x_re,
  input logic [DW-1:0] x_im,
  input logic [DW-1:0] y_re,
  input logic [DW-1:0] y_im
);
  localparam int KW = $clog2(LAT + 2);
  logic [KW-1:0] span;

  always_ff @(posedge clk) begin
    if (!rst_n || !busy) span <= '0;
    else                 span <= span + 1'b1;
  end

  AST_DONE_ONE_CYCLE:  assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);                // R7
  AST_DONE_IDLE:       assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);                // R7
  AST_DONE_LATENCY:    assert property (@(posedge clk) disable iff (!rst_n) done |-> span == KW'(LAT));     // R7
  AST_BUSY_BOUNDED:    assert property (@(posedge clk) disable iff (!rst_n) busy |-> span < KW'(LAT));      // R8
  AST_BUSY_ENDS_DONE:  assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> done);         // R7
  AST_RESULT_HELD:     assert property (@(posedge clk) disable iff (!rst_n)
                         !done |-> ($stable(x_re) && $stable(x_im) && $stable(y_re) && $stable(y_im))); // R10
endmodule

bind fft_bfly_unit fft_bfly_unit_chk #(.DW(DW), .LAT(LAT)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .x_re(x_re), .x_im(x_im), .y_re(y_re), .y_im(y_im)
);

// File: tb/test_fft_bfly_unit.sv
module test_fft_bfly_unit;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [1:0] mode = 2'd0;
  logic signed [15:0] a_re = 0, a_im = 0, b_re = 0, b_im = 0, w_re = 0, w_im = 0;
  logic busy, done;
  logic signed [15:0] x_re, x_im, y_re, y_im;

  int n_checks = 0, n_errors = 0;
  bit finished = 0;
  string cur_tag = "R10 reset", pend_tag = "", out_tag = "R10 reset";

  bit m_busy = 0, m_done = 0;
  int m_cnt = 0;
  int e_xr = 0, e_xi = 0, e_yr = 0, e_yi = 0;
  int p_xr = 0, p_xi = 0, p_yr = 0, p_yi = 0;

  fft_bfly_unit i_fft_bfly_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im), .w_re(w_re), .w_im(w_im),
    .busy(busy), .done(done), .x_re(x_re), .x_im(x_im), .y_re(y_re), .y_im(y_im)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int rs(longint s);
    longint t;
    t = (s + 64'sd16384) >>> 15;
    if (t > 32767) return 32767;
    if (t < -32768) return -32768;
    return int'(t);
  endfunction

  task automatic compute(int md, int ar, int ai, int br, int bi, int wr, int wi);
    int mr, mi, re, im, pr, pi;
    if (md[1]) begin mr = (ar - br) >>> 1; mi = (ai - bi) >>> 1; end
    else begin mr = br; mi = bi; end
    re = rs(longint'(mr) * wr - longint'(mi) * wi);
    im = rs(longint'(mr) * wi + longint'(mi) * wr);
    if (md[0]) begin pr = im; pi = (re == -32768) ? 32767 : -re; end
    else begin pr = re; pi = im; end
    if (md[1]) begin
      p_xr = (ar + br) >>> 1; p_xi = (ai + bi) >>> 1; p_yr = pr; p_yi = pi;
    end else begin
      p_xr = (ar + pr) >>> 1; p_xi = (ai + pi) >>> 1;
      p_yr = (ar - pr) >>> 1; p_yi = (ai - pi) >>> 1;
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_cnt = 0;
      e_xr = 0; e_xi = 0; e_yr = 0; e_yi = 0;
    end else begin
      m_done = 0;
      if (!m_busy) begin
        if (start) begin
          m_busy = 1; m_cnt = 0; pend_tag = cur_tag;
          compute(int'(mode), a_re, a_im, b_re, b_im, w_re, w_im);
        end
      end else begin
        m_cnt++;
        if (m_cnt == 16) begin
          m_busy = 0; m_done = 1; out_tag = pend_tag;
          e_xr = p_xr; e_xi = p_xi; e_yr = p_yr; e_yi = p_yi;
        end
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R7 done", int'(done), int'(m_done));
      chk("R8 busy", int'(busy), int'(m_busy));
      if (m_done) begin
        chk({out_tag, " x_re"}, x_re, e_xr); chk({out_tag, " x_im"}, x_im, e_xi);
        chk({out_tag, " y_re"}, y_re, e_yr); chk({out_tag, " y_im"}, y_im, e_yi);
      end else begin
        chk("R10 hold x_re", x_re, e_xr); chk("R10 hold x_im", x_im, e_xi);
        chk("R10 hold y_re", y_re, e_yr); chk("R10 hold y_im", y_im, e_yi);
      end
    end
  end

  task automatic op(string tag, int md, int ar, int ai, int br, int bi, int wr, int wi);
    @(negedge clk);
    cur_tag = tag; mode = 2'(md);
    a_re = 16'(ar); a_im = 16'(ai); b_re = 16'(br); b_im = 16'(bi); w_re = 16'(wr); w_im = 16'(wi);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (17) @(negedge clk);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_errors++; n_checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int seed;
    seed = 12345;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 reset x_re", x_re, 0); chk("R10 reset y_im", y_im, 0);
    chk("R10 reset busy", int'(busy), 0); chk("R10 reset done", int'(done), 0);

    op("R1 R2 DIT", 0, 16384, -8192, 8192, 4096, 23170, -23170);
    op("R1 R4 DIT rotated", 1, 16384, -8192, 8192, 4096, 23170, -23170);
    op("R1 R3 DIF", 2, 16384, -8192, 8192, 4096, 23170, -23170);
    op("R1 R3 R4 DIF rotated", 3, 16384, -8192, 8192, 4096, 23170, -23170);
    op("R5 product saturation", 0, 0, 0, -32768, -32768, -32768, 32767);
    op("R4 negation saturation", 1, 100, -100, 0, -32768, 0, -32768);
    op("R6 odd sums floor", 2, -32768, 32767, 32767, -32767, 32767, 0);
    op("R6 DIT extremes", 0, -32768, -32768, -32768, 32767, 32767, 32767);

    for (int k = 0; k < 12; k++) begin
      int v[6];
      for (int j = 0; j < 6; j++) begin
        seed = seed * 1103515245 + 12345;
        v[j] = (seed >>> 8) % 32768;
      end
      op("R2 R3 R5 mixed", k % 4, v[0], -v[1], v[2], v[3] - 16384, v[4], -v[5]);
    end

    @(negedge clk);
    cur_tag = "R9 captured mode"; mode = 2'd1;
    a_re = 1000; a_im = -2000; b_re = 3000; b_im = 4000; w_re = 30000; w_im = 5000;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    cur_tag = "R8 ignored start"; mode = 2'd2; a_re = -7000; b_re = 9; w_re = -1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    w_im = -32768;
    repeat (14) @(negedge clk);

    @(negedge clk);
    cur_tag = "R8 held start"; mode = 2'd3;
    a_re = 12000; a_im = 11; b_re = -5000; b_im = 20000; w_re = 0; w_im = 32767;
    start = 1'b1;
    repeat (40) @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);

    finish_run();
  end
endmodule